// File: doc/BRIEF.md
# Programmable Periodic Event Divider

This block turns a stream of reference ticks, one clock-wide pulses at a nominal 32768 Hz, into a periodic event strobe. The strobe rate is a power of two chosen by a 4-bit rate code. Code n (1 to 15) gives 2^(16-n) Hz, and code 0 silences the output. The strobe is meant to set the periodic flag of a neighbouring interrupt unit. That unit latches the flag no matter what its own enables say, so this block has no enable gating of its own.

Inside is a free-running ripple-free binary counter that advances once per reference tick. The rate code selects one counter bit as a tap, and an event is emitted when that tap makes its 0-to-1 transition. A new rate code can be written at any time. The write does not disturb the counter, so the new rate takes effect at the next transition of the newly selected tap. After reset the code is 6, which gives 1024 Hz.

All pins are plain control pins. Nothing here carries a data stream, so there is no valid/ready handshake and no back-pressure. The reference tick must be a single-cycle pulse that is synchronous to `clk`.

Top module: `periodic_rate_divider`

## Requirements
- R1: While `rst_n` is low the strobe is 0. On release the rate code is 6 and the tick counter is 0, so the first strobe follows the 16th reference tick and later strobes follow every 32nd tick.
- R2: With rate code 0 no strobe is ever produced, whatever the reference ticks do.
- R3: With rate code n in 2..15, a tick produces a strobe exactly when the counter value after that tick, modulo 2^(n-1), equals 2^(n-2). This is one strobe every 2^(n-1) ticks, or 2^(16-n) Hz at a 32768 Hz reference.
- R4: With rate code 1, every reference tick produces a strobe (32768 Hz).
- R5: A strobe is high for exactly one clock cycle, in the cycle right after the reference tick that caused it. No strobe appears without a tick in the previous cycle.
- R6: A write (`wr_en_i` high) loads `wr_rate_i` at the clock edge without clearing the counter. A tick in the same cycle as the write is judged with the old code, and every later tick with the new one.
- R7: The counter advances by one per reference tick, holds between ticks, and wraps modulo 2^14 (the widest tap needs 14 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick_i | input | 1 | One-cycle reference tick, nominal 32768 Hz |
| wr_en_i | input | 1 | Rate code write strobe |
| wr_rate_i | input | 4 | Rate code to load (0 off, n gives 2^(16-n) Hz) |
| periodic_stb_o | output | 1 | One-cycle periodic event strobe |

## Verification
A corrupted rate register or tick counter shows up only as strobes at the wrong positions in the tick stream. At fast rates that error is visible within a few ticks. At slow rates it can stay hidden for up to 2^14 ticks. The bench therefore keeps an arithmetic model of the tick count and the current code, and compares the strobe against it on every clock. It also runs a full slow-rate period and a counter wrap. The counter-preservation test uses a code change whose next strobe is only six ticks away: a counter that was cleared by the write would miss that strobe.

// File: rtl/prd_pkg.sv
package prd_pkg;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned NCODES = 1 << RATE_W;
  // the highest code taps bit NCODES-3; bits above that feed nothing
  localparam int unsigned CNT_W = NCODES - 2;
  typedef logic [RATE_W-1:0] rate_code_t;
  typedef logic [NCODES-1:0] code_sel_t;
  typedef logic [CNT_W-1:0] tick_cnt_t;
endpackage

// File: rtl/prd_rate_reg.sv
module prd_rate_reg
  import prd_pkg::*;
#(
  parameter rate_code_t RESET_CODE = rate_code_t'(6)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  rate_code_t wr_rate_i,
  output rate_code_t rate_o,
  output code_sel_t  sel_o
);
  rate_code_t rate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rate_q <= RESET_CODE;
    else if (wr_en_i) rate_q <= wr_rate_i;
  end

  // one-hot decode of the stored code; position 0 means silent
  always_comb begin
    sel_o = '0;
    sel_o[rate_q] = 1'b1;
  end

  assign rate_o = rate_q;

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(sel_o)); // R3
endmodule

// File: rtl/prd_ref_counter.sv
module prd_ref_counter
  import prd_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ref_tick_i,
  output tick_cnt_t cnt_o
);
  tick_cnt_t cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (ref_tick_i) cnt_q <= cnt_q + tick_cnt_t'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick_i |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/prd_tap_match.sv
module prd_tap_match
  import prd_pkg::*;
(
  input  tick_cnt_t cnt_i,
  input  code_sel_t sel_i,
  output logic      hit_o
);
  // hit_vec[n]: the next tick will raise tap n-2 (code 1 hits every tick)
  code_sel_t hit_vec;

  assign hit_vec[0] = 1'b0;

  for (genvar n = 1; n < NCODES; n++) begin : g_code
    if (n == 1) begin : g_every
      assign hit_vec[n] = 1'b1;
    end else if (n == 2) begin : g_lsb
      assign hit_vec[n] = ~cnt_i[0];
    end else begin : g_tap
      assign hit_vec[n] = ~cnt_i[n-2] & (&cnt_i[n-3:0]);
    end
  end

  assign hit_o = |(hit_vec & sel_i);
endmodule

// File: rtl/periodic_rate_divider.sv
module periodic_rate_divider
  import prd_pkg::*;
#(
  parameter int unsigned RESET_CODE = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick_i,
  input  logic             wr_en_i,
  input  logic [RATE_W-1:0] wr_rate_i,
  output logic             periodic_stb_o
);
  rate_code_t rate;
  code_sel_t  sel;
  tick_cnt_t  cnt;
  logic       hit;
  logic       stb_q;

  prd_rate_reg #(.RESET_CODE(rate_code_t'(RESET_CODE))) u_rate (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en_i  (wr_en_i),
    .wr_rate_i(wr_rate_i),
    .rate_o   (rate),
    .sel_o    (sel)
  );

  prd_ref_counter u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_tick_i(ref_tick_i),
    .cnt_o     (cnt)
  );

  prd_tap_match u_match (
    .cnt_i(cnt),
    .sel_i(sel),
    .hit_o(hit)
  );

  // match is evaluated against the pre-increment count and the stored code
  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else stb_q <= ref_tick_i & hit;
  end

  assign periodic_stb_o = stb_q;

  AST_STB_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    periodic_stb_o |-> $past(ref_tick_i)); // R5
  AST_CODE_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == '0) |=> !periodic_stb_o); // R2
  AST_CODE_ONE_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (rate == rate_code_t'(1) && ref_tick_i) |=> periodic_stb_o); // R4
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick_i |=> cnt == $past(cnt) + tick_cnt_t'(1)); // R7
endmodule

// File: tb/periodic_rate_divider_tb.sv
module periodic_rate_divider_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic wr_en = 1'b0;
  logic [3:0] wr_rate = 4'd0;
  logic stb;

  int checks = 0;
  int fails = 0;
  int seen = 0;
  int cycles = 0;
  bit started = 0;
  string cur_req = "R1";

  // behavioural model
  int m_cnt = 0;
  int m_code = 6;
  bit m_exp = 0;

  always #2 clk = ~clk; // 250 MHz

  periodic_rate_divider dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ref_tick_i    (ref_tick),
    .wr_en_i       (wr_en),
    .wr_rate_i     (wr_rate),
    .periodic_stb_o(stb)
  );

  function automatic bit model_hit(int c, int code);
    if (code == 0) return 0;
    if (code == 1) return 1;
    return (c % (1 << (code - 1))) == (1 << (code - 2));
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (!rst_n) begin
      m_cnt = 0; m_code = 6; m_exp = 0;
    end else begin
      int nc;
      nc = (m_cnt + 1) % 16384;
      m_exp = ref_tick && model_hit(nc, m_code);
      if (ref_tick) m_cnt = nc;
      if (wr_en) m_code = int'(wr_rate);
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (started) begin
      checks++;
      if (stb !== m_exp) begin
        fails++;
        $display("FAIL %s cycle %0d strobe=%0b expected=%0b", cur_req, cycles, stb, m_exp);
      end
      if (stb === 1'b1) seen++;
    end
    if (cycles > 190000) begin
      fails++;
      $display("FAIL watchdog expired in %s", cur_req);
      $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
      $finish;
    end
  end

  task automatic ticks(int n, int gap, bit with_wr = 0, int code = 0);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      if (with_wr && i == 0) begin wr_en = 1'b1; wr_rate = 4'(code); end
      @(negedge clk);
      ref_tick = 1'b0; wr_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
  endtask

  task automatic write_code(int code);
    wr_en = 1'b1; wr_rate = 4'(code);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(string req, int n, int gap, int exp_cnt);
    cur_req = req;
    seen = 0;
    ticks(n, gap);
    @(negedge clk); @(negedge clk);
    checks++;
    if (seen != exp_cnt) begin
      fails++;
      $display("FAIL %s strobe count=%0d expected=%0d", req, seen, exp_cnt);
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    checks++;
    if (stb !== 1'b0) begin fails++; $display("FAIL R1 reset strobe=%0b expected=0", stb); end
    rst_n = 1'b1;
    @(negedge clk);
    window("R1", 320, 0, 10);          // code 6: hits at 16,48,...,304
    write_code(0);
    window("R2", 1000, 0, 0);          // silent
    write_code(1);
    window("R4", 200, 0, 200);         // every tick
    write_code(3);
    window("R3", 400, 0, 100);         // period 4
    write_code(15);
    window("R3", 16384, 0, 1);         // one per 16384 ticks
    write_code(2);
    window("R5", 50, 3, 25);           // sparse ticks, period 2; count now 1970
    write_code(5);                     // 1970 mod 16 = 2, next hit at 1976
    window("R6", 5, 0, 0);
    window("R6", 1, 0, 1);             // only if counter was kept
    cur_req = "R6";
    seen = 0;
    ticks(1, 0, 1, 1);                 // same-cycle write: old code 5 judges count 1977
    @(negedge clk); @(negedge clk);
    checks++;
    if (seen != 0) begin fails++; $display("FAIL R6 same-cycle strobes=%0d expected=0", seen); end
    window("R6", 1, 0, 1);             // new code 1 now active
    write_code(14);
    window("R7", 16384, 0, 2);         // crosses the 2^14 wrap
    cur_req = "R1";
    rst_n = 1'b0;
    @(negedge clk); @(negedge clk);
    checks++;
    if (stb !== 1'b0) begin fails++; $display("FAIL R1 reset strobe=%0b expected=0", stb); end
    rst_n = 1'b1;
    @(negedge clk);
    window("R1", 32, 0, 1);            // default code restored, hit at 16
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule